// File: doc/BRIEF.md
# Dual-CPU Doorbell Mailbox

This peripheral lets two processors signal each other through doorbells. Each CPU owns a four-bit pending register. Any bus master can ring doorbells for a CPU by writing ones to that CPU's raise register. The receiving CPU acknowledges them by writing ones to its acknowledge register. While any pending bit of a CPU is set, that CPU's level interrupt line stays high. No payload is carried: the bits themselves are the message.

The block sits on a simple 32-bit register bus with a 4 KiB window. The bus has separate read and write strobes, a byte address and write data. Read data is registered, and an error flag pulses for one cycle after any illegal access. The top of the window holds twelve constant identification words.

Each CPU channel is a two-state machine. QUIET means no doorbell is pending. RINGING means at least one doorbell is pending. The RING transition goes from QUIET to RINGING on a raise write with a nonzero masked value. The DRAIN transition goes from RINGING to QUIET on an acknowledge write that leaves no pending bit. All other writes keep the current state. The interrupt output is high exactly in RINGING.

Top module: `doorbell_mbox`

## Requirements
- R1: Address bits [1:0] are ignored. Channel c (c = 0 or 1) has its pending register at byte offset 0x000 + 0x10*c, its raise register at +0x4 and its acknowledge register at +0x8.
- R2: A write to a raise register ORs wdata[3:0] into that channel's pending bits. wdata[31:4] is ignored.
- R3: A write to an acknowledge register clears each pending bit whose wdata bit is 1. Bits written as 0 stay unchanged, and wdata[31:4] is ignored.
- R4: irq_o[c] is high exactly when pending register c is nonzero. A write at clock edge E is reflected in both the pending register and irq_o from edge E on.
- R5: A read strobe at edge E puts its data on rdata_o from edge E until the next edge. Pending reads return the bits in [3:0] and zero above. In a cycle that does not follow a read strobe, rdata_o is 0.
- R6: Raise and acknowledge registers read as 0. Writes to pending or ID registers change nothing. Each such direction violation raises err_o for the one cycle after the strobe.
- R7: Reads of unmapped offsets return 0, and writes to them change nothing. Both raise err_o for one cycle. Legal accesses and idle cycles leave err_o low.
- R8: Words 0xFD0..0xFFC read, in address order, as 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each in bits [7:0] with zero above.
- R9: Reset (rst_ni low) clears both pending registers, irq_o, rdata_o and err_o.
- R10: Raise and acknowledge writes to one channel never change the other channel's pending bits or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 12 | Byte address in the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle illegal-access flag |
| irq_o | output | 2 | Per-CPU level doorbell interrupt |

## Verification
The assertions assume the strobes, address and write data are known values at every clock edge once reset is released. They also assume reset is held for at least one edge. The bench drives all inputs on the falling edge and never leaves them unknown. Between directed transactions it returns both strobes to zero. Its randomized phase issues at most one strobe per cycle, so each cycle is a single well-defined access that the reference model can replay.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [2:0] {
        ACC_STAT,
        ACC_SET,
        ACC_CLR,
        ACC_ID,
        ACC_NONE
    } acc_kind_e;

    typedef enum logic {
        CH_QUIET,
        CH_RINGING
    } ch_state_e;

    // Identification bytes, indexed from the lowest ID word upward.
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] v;
        unique case (idx)
            4'd0:    v = 8'h04;
            4'd4:    v = 8'h56;
            4'd5:    v = 8'hB8;
            4'd6:    v = 8'h0B;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'hF0;
            4'd10:   v = 8'h05;
            4'd11:   v = 8'hB1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_CPU     = 2,
    parameter int CHAN_STRIDE = 16,
    parameter int ID_BASE     = 'hFD0,
    parameter int ID_WORDS    = 12,
    localparam int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W      = $clog2(ID_WORDS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [CPU_W-1:0]  cpu_o,
    output logic [IDX_W-1:0]  id_idx_o
);

    localparam int WORD_W   = ADDR_W - 2;
    localparam int STRIDE_W = CHAN_STRIDE / 4;
    localparam logic [WORD_W-1:0] ID_FIRST = WORD_W'(ID_BASE / 4);
    localparam logic [WORD_W-1:0] ID_LAST  = WORD_W'(ID_BASE / 4 + ID_WORDS - 1);

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_byte_lane;
    logic [WORD_W-1:0] id_off;

    assign word             = addr_i[ADDR_W-1:2];
    assign unused_byte_lane = addr_i[1:0];
    assign id_off           = word - ID_FIRST;

    always_comb begin
        kind_o   = ACC_NONE;
        cpu_o    = '0;
        id_idx_o = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (word == WORD_W'(c * STRIDE_W)) begin
                kind_o = ACC_STAT;
                cpu_o  = CPU_W'(c);
            end else if (word == WORD_W'(c * STRIDE_W + 1)) begin
                kind_o = ACC_SET;
                cpu_o  = CPU_W'(c);
            end else if (word == WORD_W'(c * STRIDE_W + 2)) begin
                kind_o = ACC_CLR;
                cpu_o  = CPU_W'(c);
            end
        end
        if (word >= ID_FIRST && word <= ID_LAST) begin
            kind_o   = ACC_ID;
            id_idx_o = id_off[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
#(
    parameter int BELL_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [BELL_W-1:0] bits_i,
    output logic [BELL_W-1:0] status_o,
    output logic              irq_o
);

    ch_state_e         state_q, state_d;
    logic [BELL_W-1:0] pend_q, pend_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CH_QUIET;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state: RING and DRAIN transitions
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        if (set_en_i)      pend_d = pend_q | bits_i;
        else if (clr_en_i) pend_d = pend_q & ~bits_i;
        unique case (state_q)
            CH_QUIET:   if (set_en_i && (|bits_i)) state_d = CH_RINGING;
            CH_RINGING: if (clr_en_i && ((pend_q & ~bits_i) == '0)) state_d = CH_QUIET;
            default:    state_d = CH_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        status_o = pend_q;
        irq_o    = (state_q == CH_RINGING);
    end

    // R2
    set_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> ((status_o & $past(bits_i)) == $past(bits_i)));

    // R3
    clr_drops_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en_i && !set_en_i) |=> ((status_o & $past(bits_i)) == '0));

    // R4
    irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (status_o != '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_en_i && !clr_en_i) |=> $stable(status_o));

endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int NUM_CPU     = 2,
    parameter int BELL_W      = 4,
    parameter int CHAN_STRIDE = 16,
    parameter int ID_BASE     = 'hFD0,
    parameter int ID_WORDS    = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic [NUM_CPU-1:0] irq_o
);

    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int IDX_W = $clog2(ID_WORDS);

    acc_kind_e         kind;
    logic [CPU_W-1:0]  cpu;
    logic [IDX_W-1:0]  id_idx;
    logic [BELL_W-1:0] bell_bits;
    logic [DATA_W-BELL_W-1:0] unused_wdata_hi;
    logic [BELL_W-1:0] stat_w [NUM_CPU];

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              rd_bad, wr_bad, err_q;

    assign bell_bits       = wdata_i[BELL_W-1:0];
    assign unused_wdata_hi = wdata_i[DATA_W-1:BELL_W];

    mbox_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_CPU    (NUM_CPU),
        .CHAN_STRIDE(CHAN_STRIDE),
        .ID_BASE    (ID_BASE),
        .ID_WORDS   (ID_WORDS)
    ) decode_i (
        .addr_i  (addr_i),
        .kind_o  (kind),
        .cpu_o   (cpu),
        .id_idx_o(id_idx)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chan
        logic hit;
        assign hit = wr_en_i && (cpu == CPU_W'(c));
        mbox_channel #(
            .BELL_W(BELL_W)
        ) chan_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .set_en_i(hit && (kind == ACC_SET)),
            .clr_en_i(hit && (kind == ACC_CLR)),
            .bits_i  (bell_bits),
            .status_o(stat_w[c]),
            .irq_o   (irq_o[c])
        );
    end

    // read mux and direction-rule check
    always_comb begin
        rdata_d = '0;
        rd_bad  = 1'b0;
        wr_bad  = 1'b0;
        unique case (kind)
            ACC_STAT: begin
                if (rd_en_i) rdata_d = DATA_W'(stat_w[cpu]);
                wr_bad = wr_en_i;
            end
            ACC_SET, ACC_CLR: rd_bad = rd_en_i;
            ACC_ID: begin
                if (rd_en_i) rdata_d = DATA_W'(id_byte(4'(id_idx)));
                wr_bad = wr_en_i;
            end
            default: begin
                rd_bad = rd_en_i;
                wr_bad = wr_en_i;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            err_q   <= rd_bad || wr_bad;
        end
    end

    assign rdata_o = rdata_q;
    assign err_o   = err_q;

    // R7
    unmapped_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_en_i || wr_en_i) && kind == ACC_NONE) |=> (err_o && rdata_o == '0));

    // R6
    wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && (kind == ACC_SET || kind == ACC_CLR)) |=> (rdata_o == '0 && err_o));

    // R5
    idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == '0));

    // R8
    id_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !wr_en_i && kind == ACC_ID) |=> (rdata_o[DATA_W-1:8] == '0 && !err_o));

endmodule

// File: tb/doorbell_mbox_tb.sv
`timescale 1ns/1ps
module doorbell_mbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [1:0]  irq;

    always #2.5 clk = ~clk;

    doorbell_mbox dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .rd_en_i(rd),
        .wr_en_i(wr),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .err_o  (err),
        .irq_o  (irq)
    );

    int total = 0;
    int bad   = 0;
    string tag = "R9";
    bit live = 1'b0;

    int          m_stat [2];
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;
    int          id_tab [12] = '{'h04, 'h00, 'h00, 'h00, 'h56, 'hB8, 'h0B, 'h00,
                                 'h0D, 'hF0, 'h05, 'hB1};

    initial begin
        m_stat[0] = 0;
        m_stat[1] = 0;
    end

    // behavioural reference model, one access per edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat[0] = 0;
            m_stat[1] = 0;
            m_rdata   = '0;
            m_err     = 1'b0;
        end else begin
            int w;
            int ch;
            int off;
            logic [31:0] rv;
            logic        e;
            w   = int'(addr) / 4;
            ch  = w / 4;
            off = w % 4;
            rv  = '0;
            e   = 1'b0;
            if (rd) begin
                if (ch < 2 && off == 0) rv = m_stat[ch];
                else if (ch < 2 && (off == 1 || off == 2)) e = 1'b1;
                else if (w >= 'h3F4) rv = id_tab[w - 'h3F4];
                else e = 1'b1;
            end
            if (wr) begin
                if (ch < 2 && off == 1) m_stat[ch] = m_stat[ch] | int'(wdata & 32'hF);
                else if (ch < 2 && off == 2) m_stat[ch] = m_stat[ch] & ~int'(wdata & 32'hF);
                else e = 1'b1;
            end
            m_rdata = rv;
            m_err   = e;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            total += 3;
            if (rdata !== m_rdata) begin
                bad++;
                $display("FAIL %s rdata act=%h exp=%h", tag, rdata, m_rdata);
            end
            if (err !== m_err) begin
                bad++;
                $display("FAIL %s err act=%b exp=%b", tag, err, m_err);
            end
            if (irq !== {m_stat[1] != 0, m_stat[0] != 0}) begin
                bad++;
                $display("FAIL %s irq act=%b exp=%b", tag, irq,
                         {m_stat[1] != 0, m_stat[0] != 0});
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_op(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_op(input logic [11:0] a, output logic [31:0] v, output logic e);
        @(negedge clk);
        rd = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
        e = err;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] v;
        logic        e;
        rd_op(a, v, e);
        check(req, v, exp);
        check(req, 32'(e), 32'(exp_err));
    endtask

    initial begin
        logic [31:0] v;
        logic        e;
        repeat (3) @(posedge clk);
        #1 live = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        tag = "R9";
        check("R9", 32'(irq), 32'h0);
        check("R9", rdata, 32'h0);
        rd_chk("R9", 12'h000, 32'h0, 1'b0);
        rd_chk("R9", 12'h010, 32'h0, 1'b0);

        // R8: identification words
        tag = "R8";
        for (int k = 0; k < 12; k++)
            rd_chk("R8", 12'(12'hFD0 + 4 * k), 32'(id_tab[k]), 1'b0);

        // R2 and R10: raise on channel 0, channel 1 untouched
        tag = "R2";
        wr_op(12'h004, 32'hFFFF_FFF5);
        check("R4", 32'(irq), 32'h1);
        rd_chk("R2", 12'h000, 32'h5, 1'b0);
        tag = "R10";
        rd_chk("R10", 12'h010, 32'h0, 1'b0);
        wr_op(12'h004, 32'h0000_0002);
        rd_chk("R2", 12'h000, 32'h7, 1'b0);

        // R3: partial acknowledge keeps zero-written bits
        tag = "R3";
        wr_op(12'h008, 32'hFFFF_FFF1);
        rd_chk("R3", 12'h000, 32'h6, 1'b0);
        check("R4", 32'(irq), 32'h1);
        wr_op(12'h008, 32'h0000_0006);
        check("R4", 32'(irq), 32'h0);

        // R1: byte-lane bits ignored, channel 1 decode
        tag = "R1";
        wr_op(12'h017, 32'h0000_0009);
        rd_chk("R1", 12'h013, 32'h9, 1'b0);
        check("R10", 32'(irq), 32'h2);
        rd_chk("R10", 12'h000, 32'h0, 1'b0);
        wr_op(12'h005, 32'h0000_0008);
        wr_op(12'h01A, 32'h0000_0001);
        rd_chk("R1", 12'h010, 32'h8, 1'b0);
        rd_chk("R10", 12'h000, 32'h8, 1'b0);

        // R6: direction rules
        tag = "R6";
        rd_chk("R6", 12'h004, 32'h0, 1'b1);
        rd_chk("R6", 12'h018, 32'h0, 1'b1);
        wr_op(12'h000, 32'h0000_000F);
        rd_chk("R6", 12'h000, 32'h8, 1'b0);
        wr_op(12'hFE0, 32'h0000_00FF);
        rd_chk("R6", 12'hFE0, 32'h56, 1'b0);

        // R7: unmapped offsets
        tag = "R7";
        rd_chk("R7", 12'h00C, 32'h0, 1'b1);
        rd_chk("R7", 12'h800, 32'h0, 1'b1);
        wr_op(12'h024, 32'h0000_000F);
        check("R7", 32'(irq), 32'h3);
        rd_chk("R7", 12'h000, 32'h8, 1'b0);
        rd_chk("R7", 12'h010, 32'h8, 1'b0);

        // R5: idle cycles give zero read data
        tag = "R5";
        @(negedge clk);
        check("R5", rdata, 32'h0);

        // back-to-back randomized accesses, model compared every clock
        tag = "R4";
        for (int n = 0; n < 600; n++) begin
            int pick;
            @(negedge clk);
            pick = int'($urandom_range(0, 15));
            case (pick % 8)
                0: addr = 12'h000;
                1: addr = 12'h004;
                2: addr = 12'h008;
                3: addr = 12'h010;
                4: addr = 12'h014;
                5: addr = 12'h018;
                6: addr = 12'(12'hFD0 + 4 * $urandom_range(0, 11));
                default: addr = 12'($urandom);
            endcase
            addr[1:0] = 2'($urandom);
            wdata = $urandom;
            rd = (pick >= 8 && pick < 12);
            wr = (pick < 8) || (pick >= 12 && pick < 15);
        end
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule